// File: doc/BRIEF.md
# Three-Stage C-Element Ring Distributor

This block is a clocked model of a self-timed ring distributor. Three stages are connected in a loop. Each stage is an inverting Muller C-element. A stage drives its output to 1 once every input it sees is 0, and drives it to 0 once every input is 1. In every other case it keeps its value. Stage `i` watches the stage behind it, `i-1`, and the inverse of the stage ahead of it, `i+1`, with indices taken modulo three. In any legal state exactly one stage is excited, so one clock edge corresponds to one step of the ring.

The ring state alternates between two groups: states with two ones and one zero, and states with one one and two zeros. An AND-OR majority term marks which group the ring is in. Because the group changes on every step, the indicator toggles three times as often as any single stage. That makes it a completion clock at three times the stage rate.

The stage outputs also locate the ring among its six positions. A decoder turns them into a one-hot position word, so the block doubles as a six-position positional counter. Reset loads a legal state with exactly one stage at 0.

Top module: `ring_dist_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stages load the reset state: every stage at 1 except stage `RST_ZERO_STAGE` (default 0), so `stage_o` = 3'b110 as {stage2,stage1,stage0}. The state holds until the first edge with `rst_n` high.
- R2: On every edge with `rst_n` high, exactly one bit of `stage_o` changes.
- R3: After reset, `stage_o` always has exactly one or exactly two bits set.
- R4: Stage `i` takes a new value only on an edge where `stage_o[i-1]` equals the inverse of `stage_o[i+1]` (indices modulo 3). The new value is the inverse of `stage_o[i-1]`.
- R5: From the default reset state, successive edges give the sequence 110, 010, 011, 001, 101, 100, and then 110 again.
- R6: `ind_o` is 1 exactly when two stages are 1. It therefore toggles on every stepping edge.
- R7: Once running, each stage toggles exactly once in every three stepping edges, which gives a full stage period of six edges.
- R8: `pos_o` is one-hot. Its bit k marks position k, where positions 0, 2 and 4 have the zero at stage 0, 2 and 1, and positions 1, 3 and 5 have the single one at stage 1, 0 and 2.
- R9: A reset pulse of any length applied mid-run returns the ring to the reset state, and stepping resumes from position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step clock; one ring transition per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_o | output | 3 | Registered C-element stage outputs |
| ind_o | output | 1 | Group-change indicator (two ones = 1) |
| pos_o | output | 6 | One-hot ring position |

## Verification
The hardest situation to create from the ports is a reset that lands at an arbitrary point in the six-step cycle, including one-cycle pulses and back-to-back pulses. Only then does the bench confirm that re-entry always lands on position 0 and that stage periods measured across the break are not counted. The stimulus uses seeded random reset pulses of one to three cycles, spread over thousands of edges, together with directed long and single-cycle resets. After each reset, the bench checks a full pass through the sequence against its own table.

// File: rtl/ring_dist_pkg.sv
package ring_dist_pkg;
    localparam int STAGES = 3;
    localparam int PHASES = 2 * STAGES;

    typedef logic [STAGES-1:0] stage_vec_t;
    typedef logic [PHASES-1:0] pos_vec_t;

    typedef struct packed {
        stage_vec_t stage;
    } ring_state_t;

    function automatic int unsigned wrap_idx(input int i);
        return unsigned'((i + STAGES) % STAGES);
    endfunction

    function automatic stage_vec_t reset_state(input int unsigned zero_stage);
        stage_vec_t v;
        v = '1;
        v[zero_stage] = 1'b0;
        return v;
    endfunction
endpackage

// File: rtl/ring_cell.sv
module ring_cell (
    input  logic back_i,
    input  logic fwd_n_i,
    input  logic y_q_i,
    output logic y_d_o
);
    always_comb begin
        if (back_i && fwd_n_i) begin
            y_d_o = 1'b0;
        end else if (!back_i && !fwd_n_i) begin
            y_d_o = 1'b1;
        end else begin
            y_d_o = y_q_i;
        end
    end
endmodule

// File: rtl/group_indicator.sv
module group_indicator
    import ring_dist_pkg::*;
(
    input  stage_vec_t stage_i,
    output logic       ind_o
);
    logic [STAGES-1:0] pair_and;

    for (genvar g = 0; g < STAGES; g++) begin : g_pair
        assign pair_and[g] = stage_i[g] & stage_i[(g + 1) % STAGES];
    end

    assign ind_o = |pair_and;
endmodule

// File: rtl/phase_decoder.sv
module phase_decoder
    import ring_dist_pkg::*;
(
    input  stage_vec_t stage_i,
    input  logic       two_ones_i,
    output pos_vec_t   pos_o
);
    // zero-at-stage s maps to even position, lone-one-at-stage s to odd
    function automatic int unsigned even_pos(input int unsigned s);
        return unsigned'((2 * ((STAGES - int'(s)) % STAGES)) % PHASES);
    endfunction

    function automatic int unsigned odd_pos(input int unsigned s);
        return unsigned'(2 * ((1 - int'(s) + STAGES) % STAGES) + 1);
    endfunction

    always_comb begin
        pos_o = '0;
        for (int s = 0; s < STAGES; s++) begin
            if (two_ones_i && !stage_i[s]) begin
                pos_o[even_pos(unsigned'(s))] = 1'b1;
            end
            if (!two_ones_i && stage_i[s]) begin
                pos_o[odd_pos(unsigned'(s))] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ring_dist_top.sv
module ring_dist_top
    import ring_dist_pkg::*;
#(
    parameter int unsigned RST_ZERO_STAGE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] stage_o,
    output logic              ind_o,
    output logic [PHASES-1:0] pos_o
);
    localparam stage_vec_t RST_VEC = reset_state(RST_ZERO_STAGE);

    ring_state_t ring_d;
    ring_state_t ring_q;
    stage_vec_t  cell_d;

    for (genvar i = 0; i < STAGES; i++) begin : g_cell
        ring_cell cell_i (
            .back_i  (ring_q.stage[(i + STAGES - 1) % STAGES]),
            .fwd_n_i (~ring_q.stage[(i + 1) % STAGES]),
            .y_q_i   (ring_q.stage[i]),
            .y_d_o   (cell_d[i])
        );
    end

    always_comb begin
        ring_d       = ring_q;
        ring_d.stage = cell_d;
        if (!rst_n) begin
            ring_d.stage = RST_VEC;
        end
    end

    always_ff @(posedge clk) begin
        ring_q <= ring_d;
    end

    group_indicator ind_i (
        .stage_i (ring_q.stage),
        .ind_o   (ind_o)
    );

    phase_decoder dec_i (
        .stage_i    (ring_q.stage),
        .two_ones_i (ind_o),
        .pos_o      (pos_o)
    );

    assign stage_o = ring_q.stage;
endmodule

// File: rtl/ring_dist_chk.sv
module ring_dist_chk
    import ring_dist_pkg::*;
#(
    parameter int unsigned RST_ZERO_STAGE = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAGES-1:0] stage_o,
    input logic              ind_o,
    input logic [PHASES-1:0] pos_o
);
    localparam stage_vec_t RST_VEC = reset_state(RST_ZERO_STAGE);

    AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> stage_o == RST_VEC); // R1
    AST_ONE_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones(stage_o ^ $past(stage_o)) == 1); // R2
    AST_LEGAL_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(stage_o) == 1 || $countones(stage_o) == 2)); // R3
    AST_IND_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ind_o != $past(ind_o)); // R6
    AST_IND_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ind_o == ($countones(stage_o) == 2)); // R6
    AST_POS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones(pos_o) == 1); // R8

    for (genvar i = 0; i < STAGES; i++) begin : g_rule
        AST_CELL_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && stage_o[i] != $past(stage_o[i])) |->
            ($past(stage_o[(i + STAGES - 1) % STAGES]) != $past(stage_o[(i + 1) % STAGES])
             && stage_o[i] == !$past(stage_o[(i + STAGES - 1) % STAGES]))); // R4
    end
endmodule

bind ring_dist_top ring_dist_chk #(.RST_ZERO_STAGE(RST_ZERO_STAGE)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .stage_o (stage_o),
    .ind_o   (ind_o),
    .pos_o   (pos_o)
);

// File: tb/ring_dist_top_tb_top.sv
module ring_dist_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] stage_o;
    logic       ind_o;
    logic [5:0] pos_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    logic [2:0] exp_q = 3'b110;
    logic [2:0] prev_s;
    int         since [3];
    bit         tvalid [3];

    always #5 clk = ~clk;

    ring_dist_top dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .stage_o (stage_o),
        .ind_o   (ind_o),
        .pos_o   (pos_o)
    );

    // inverter-ring view: the stage equal to its predecessor flips
    function automatic logic [2:0] model_next(input logic [2:0] s);
        logic [2:0] n;
        n = s;
        for (int i = 0; i < 3; i++) begin
            if (s[i] == s[(i + 2) % 3]) n[i] = ~s[i];
        end
        return n;
    endfunction

    function automatic logic [5:0] model_pos(input logic [2:0] s);
        case (s)
            3'b110: return 6'b000001;
            3'b010: return 6'b000010;
            3'b011: return 6'b000100;
            3'b001: return 6'b001000;
            3'b101: return 6'b010000;
            3'b100: return 6'b100000;
            default: return 6'b000000;
        endcase
    endfunction

    function automatic logic model_ind(input logic [2:0] s);
        return (s[0] + s[1] + s[2]) == 2;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        exp_q  <= rst_n ? model_next(exp_q) : 3'b110;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    task automatic sample(input bit was_rst);
        check("R1/R5 state", {5'd0, stage_o}, {5'd0, exp_q});
        check("R6 indicator", {7'd0, ind_o}, {7'd0, model_ind(exp_q)});
        check("R8 position", {2'd0, pos_o}, {2'd0, model_pos(exp_q)});
        if (!was_rst) begin
            check("R3 group", {7'd0, ($countones(stage_o) == 1 || $countones(stage_o) == 2)}, 8'd1);
            check("R2 one step", 8'($countones(stage_o ^ prev_s)), 8'd1);
            for (int i = 0; i < 3; i++) begin
                since[i]++;
                if (stage_o[i] != prev_s[i]) begin
                    if (tvalid[i]) check("R7 stage period", 8'(since[i]), 8'd3);
                    tvalid[i] = 1;
                    since[i] = 0;
                end
            end
        end else begin
            for (int i = 0; i < 3; i++) begin
                tvalid[i] = 0;
                since[i] = 0;
            end
        end
        prev_s = stage_o;
    endtask

    task automatic step(input logic r);
        bit was;
        rst_n = r;
        @(posedge clk);
        was = !r;
        @(negedge clk);
        sample(was);
    endtask

    initial begin
        logic [2:0] seq [6];
        seq[0] = 3'b110; seq[1] = 3'b010; seq[2] = 3'b011;
        seq[3] = 3'b001; seq[4] = 3'b101; seq[5] = 3'b100;
        void'($urandom(32'd20240611));
        @(negedge clk);
        for (int k = 0; k < 4; k++) step(1'b0);
        check("R1 reset state", {5'd0, stage_o}, 8'h06);
        // directed R5 order through two full turns
        for (int k = 1; k <= 12; k++) begin
            step(1'b1);
            check("R5 order", {5'd0, stage_o}, {5'd0, seq[k % 6]});
        end
        // directed single-cycle mid-run reset
        step(1'b0);
        check("R9 one-cycle reset", {5'd0, stage_o}, 8'h06);
        step(1'b1);
        check("R9 resume", {5'd0, stage_o}, 8'h02);
        // directed long reset
        for (int k = 0; k < 7; k++) step(1'b0);
        check("R9 long reset", {2'd0, pos_o}, 8'h01);
        // random reset pulses
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 96) == 0) begin
                int len;
                len = int'($urandom_range(1, 3));
                for (int j = 0; j < len; j++) step(1'b0);
                check("R9 random reset", {5'd0, stage_o}, 8'h06);
            end else begin
                step(1'b1);
            end
        end
        done = 1;
        finish_run();
    end
endmodule